// File: doc/BRIEF.md
# EEPROM Protection and Configuration Register Block

This block holds the configuration register and the block-protect register of a 2 KB non-volatile array at addresses 0x0800–0x0FFF. A bus writes either register. Some fields are open at all times. Some accept writes only in special (test) mode. The lock field accepts one write in normal mode, and the flash-open field can only be cleared in normal mode. While the lock is set, or while a program/erase pulse is active, the protection register keeps its value.

A combinational address checker reports whether a given program or erase target falls in a protected region. The block-protect regions sit side by side and halve in size toward the top of the array. When the shadow word is mapped in, it occupies the two lowest bytes of the topmost region, and its own protect bit then also applies to those bytes. A second flag tells the erase sequencer whether a bulk or row erase must be refused. The array, the cycle timing and the erase sequencing are outside this block.

The normal-mode write-once rule for the lock field is held in a four-state machine, with one state for each pairing of lock value (open/shut) and once-token state (fresh/spent). `LK_OPEN_FRESH` is the reset state. A normal-mode configuration write moves `LK_OPEN_FRESH` or `LK_SHUT_FRESH` to `LK_SHUT_SPENT` when data bit 1 is 1, and to `LK_OPEN_SPENT` otherwise. A special-mode configuration write moves between `LK_OPEN_x` and `LK_SHUT_x` according to data bit 1 and keeps the fresh/spent half. A normal-mode write in a `_SPENT` state stays where it is.

Top module: `eep_prot_cfg`

## Requirements
- R1: Reset is synchronous and active low. After reset, configuration bits 7:4 equal `shadow_nib[3:0]`, bit 3 = 1, bit 2 (wait-stop) = 1, bit 1 (lock) = 0 and bit 0 (dummy) = 0. The protection register reads 0xFF.
- R2: A write with `bus_sel`=1 loads protection bits 7 and 5:0 from the data only when `pgm_active`=0 and lock=0; otherwise the write is ignored. Protection bit 6 always reads 1.
- R3: In normal mode (`special_mode`=0), only the first configuration write (`bus_sel`=0) after reset sets the lock bit, to data bit 1. Later normal-mode writes leave the lock unchanged.
- R4: In special mode, every configuration write sets the lock bit to data bit 1. Special-mode writes do not use up the normal-mode single write.
- R5: Configuration bits 7:5 (bit 7 debug-lockout disable, bit 6 shadow disable, bit 5 reserved) change only on special-mode writes.
- R6: Configuration bit 4 (flash-open) takes any value in special mode. In normal mode a write can only clear it (new value = old AND data bit 4).
- R7: Configuration bits 2 and 0 take the written data on any configuration write. Bit 3 always reads 1.
- R8: Within 0x0800–0x0FFF, `chk_protected` is 1 when the protect bit for the region holding `chk_addr` is 1. The regions are bit 5: 0x0800–0x0BFF, bit 4: 0x0C00–0x0DFF, bit 3: 0x0E00–0x0EFF, bit 2: 0x0F00–0x0F7F, bit 1: 0x0F80–0x0FBF, bit 0: 0x0FC0–0x0FFF.
- R9: For `chk_addr` below 0x0800, `chk_protected` = 0.
- R10: `shadow_visible` equals the inverse of configuration bit 6. While it is 1, addresses 0x0FC0–0x0FC1 also count as protected when protection bit 7 is 1.
- R11: `erase_kind` is coded 00 bulk, 01 row, 1x byte/word. `bulk_row_block` is 1 when `bulk_prot`=1 and the kind is bulk or row, or when the kind is bulk and the shadow word is not visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| special_mode | input | 1 | 1 = special (test) mode, 0 = normal mode |
| pgm_active | input | 1 | Program/erase pulse currently applied |
| shadow_nib | input | 4 | Shadow-word high-byte bits 7:4, loaded at reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = configuration register, 1 = protection register |
| bus_wdata | input | 8 | Write data |
| chk_addr | input | 12 | Program/erase target address to check |
| erase_kind | input | 2 | Erase granularity of the pending operation |
| bulk_prot | input | 1 | Bulk-protect bit from the program control register |
| cfg_q | output | 8 | Configuration register contents |
| prot_q | output | 8 | Protection register contents |
| chk_protected | output | 1 | Target address is protected |
| shadow_visible | output | 1 | Shadow word mapped over 0x0FC0–0x0FC1 |
| bulk_row_block | output | 1 | Bulk or row erase must be refused |

## Verification
The address checker is first swept across every region boundary pair (last byte of one region, first byte of the next, 0x07FF and the shadow bytes), each time with a single protect bit set. This shows whether each bit maps to exactly its own region and whether the shadow bytes pick up bit 7 only while the shadow word is visible. Directed write sequences then separate the first normal-mode lock write from later ones, and special-mode writes from normal-mode ones. Long stretches of pseudo-random writes follow, mixing modes, `pgm_active`, data and targets over several resets with different shadow values. A behavioural model is compared on every clock, which catches writes that slip through a frozen or mode-gated field.

// File: rtl/eep_prot_pkg.sv
package eep_prot_pkg;

    localparam int DATA_W = 8;

    // configuration register field positions (upper nibble mirrors shadow bits 7:4)
    localparam int CFG_DBG_UNLOCK = 7;
    localparam int CFG_SHW_OFF    = 6;
    localparam int CFG_RSVD       = 5;
    localparam int CFG_FLASH_OPEN = 4;
    localparam int CFG_FIXED_ONE  = 3;
    localparam int CFG_WAIT_STOP  = 2;
    localparam int CFG_LOCK       = 1;
    localparam int CFG_DUMMY      = 0;

    // protection register field positions
    localparam int PRT_SHW      = 7;
    localparam int PRT_FIXED    = 6;

    typedef enum logic [1:0] {
        LK_OPEN_FRESH = 2'b00,
        LK_OPEN_SPENT = 2'b01,
        LK_SHUT_FRESH = 2'b10,
        LK_SHUT_SPENT = 2'b11
    } lock_state_t;

    typedef enum logic [1:0] {
        ERS_BULK = 2'b00,
        ERS_ROW  = 2'b01,
        ERS_BYTE = 2'b10,
        ERS_WORD = 2'b11
    } erase_kind_t;

endpackage

// File: rtl/eep_lock_fsm.sv
module eep_lock_fsm
    import eep_prot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic special,
    input  logic lock_wbit,
    output logic lock
);

    lock_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LK_OPEN_FRESH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            unique case (st_q)
                LK_OPEN_FRESH, LK_SHUT_FRESH: begin
                    if (special) st_d = lock_wbit ? LK_SHUT_FRESH : LK_OPEN_FRESH;
                    else         st_d = lock_wbit ? LK_SHUT_SPENT : LK_OPEN_SPENT;
                end
                LK_OPEN_SPENT, LK_SHUT_SPENT: begin
                    if (special) st_d = lock_wbit ? LK_SHUT_SPENT : LK_OPEN_SPENT;
                end
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            LK_SHUT_FRESH, LK_SHUT_SPENT: lock = 1'b1;
            LK_OPEN_FRESH, LK_OPEN_SPENT: lock = 1'b0;
        endcase
    end

    // R3: once the normal-mode token is spent, normal writes leave the lock alone
    p_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !special && (st_q == LK_OPEN_SPENT || st_q == LK_SHUT_SPENT)) |=> $stable(lock));

    // R4: special-mode writes always land
    p_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && special) |=> (lock == $past(lock_wbit)));

endmodule

// File: rtl/eep_cfg_reg.sv
module eep_cfg_reg
    import eep_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              special,
    input  logic [3:0]        shadow_nib,
    input  logic [3:0]        hi_wdata,
    input  logic              wstop_wdata,
    input  logic              dummy_wdata,
    input  logic              lock_bit,
    output logic [DATA_W-1:0] cfg_q
);

    localparam int NIB_FOPEN = CFG_FLASH_OPEN - 4;

    logic [3:0] hi_q;
    logic       wstop_q;
    logic       dummy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= shadow_nib;
            wstop_q <= 1'b1;
            dummy_q <= 1'b0;
        end else if (cfg_wr) begin
            if (special) begin
                hi_q <= hi_wdata;
            end else begin
                hi_q[NIB_FOPEN] <= hi_q[NIB_FOPEN] & hi_wdata[NIB_FOPEN];
            end
            wstop_q <= wstop_wdata;
            dummy_q <= dummy_wdata;
        end
    end

    always_comb begin
        cfg_q                = '0;
        cfg_q[7:4]           = hi_q;
        cfg_q[CFG_FIXED_ONE] = 1'b1;
        cfg_q[CFG_WAIT_STOP] = wstop_q;
        cfg_q[CFG_LOCK]      = lock_bit;
        cfg_q[CFG_DUMMY]     = dummy_q;
    end

    // R5: mode-gated fields hold across normal-mode writes
    p_mode_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !special) |=> $stable(cfg_q[CFG_DBG_UNLOCK:CFG_RSVD]));

    // R6: flash-open can never be raised from normal mode
    p_fopen_noset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !special) |=> !$rose(cfg_q[CFG_FLASH_OPEN]));

endmodule

// File: rtl/eep_prot_reg.sv
module eep_prot_reg
    import eep_prot_pkg::*;
#(
    parameter int N_BLK = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_wr,
    input  logic              pgm_active,
    input  logic              lock_bit,
    input  logic              shw_wdata,
    input  logic [N_BLK-1:0]  blk_wdata,
    output logic [DATA_W-1:0] prot_q
);

    logic             shw_q;
    logic [N_BLK-1:0] blk_q;
    logic             open_wr;

    assign open_wr = prot_wr && !pgm_active && !lock_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shw_q <= 1'b1;
            blk_q <= '1;
        end else if (open_wr) begin
            shw_q <= shw_wdata;
            blk_q <= blk_wdata;
        end
    end

    always_comb begin
        prot_q              = '1;
        prot_q[PRT_SHW]     = shw_q;
        prot_q[N_BLK-1:0]   = blk_q;
    end

    // R2: frozen while locked or while a pulse is applied
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && (pgm_active || lock_bit)) |=> $stable(prot_q));

    // R2: an open write lands on the block bits
    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !pgm_active && !lock_bit) |=> (prot_q[N_BLK-1:0] == $past(blk_wdata)));

endmodule

// File: rtl/eep_addr_check.sv
module eep_addr_check #(
    parameter int          ADDR_W    = 12,
    parameter int unsigned ARR_BASE  = 32'h0800,
    parameter int unsigned ARR_BYTES = 2048,
    parameter int          N_BLK     = 6,
    parameter int unsigned SHW_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_BLK-1:0]  blk_prot,
    input  logic              shw_prot,
    input  logic              shw_visible,
    output logic              hit_prot,
    output logic              shw_hit
);

    localparam int unsigned ARR_TOP = ARR_BASE + ARR_BYTES;
    localparam int unsigned SMALLEST = ARR_BYTES >> (N_BLK - 1);
    localparam int unsigned SHW_LO  = ARR_TOP - SMALLEST;

    logic [31:0]      a_ext;
    logic [N_BLK-1:0] in_blk;

    assign a_ext = 32'(addr);

    // region k (k>0) is ARR_BYTES >> (N_BLK-k) long and ends where region k-1 starts
    for (genvar k = 0; k < N_BLK; k++) begin : g_blk
        localparam int unsigned SZ = (k == 0) ? SMALLEST : (ARR_BYTES >> (N_BLK - k));
        localparam int unsigned LO = (k == 0) ? (ARR_TOP - SZ) : (ARR_TOP - 2 * SZ);
        assign in_blk[k] = (a_ext >= LO) && (a_ext < LO + SZ);
    end

    assign shw_hit  = shw_visible && (a_ext >= SHW_LO) && (a_ext < SHW_LO + SHW_BYTES);
    assign hit_prot = (|(in_blk & blk_prot)) | (shw_hit & shw_prot);

    // R8: regions never overlap
    p_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_blk));

    // R9: nothing below the array is ever reported protected
    p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ext < ARR_BASE) |-> !hit_prot);

endmodule

// File: rtl/eep_prot_cfg.sv
module eep_prot_cfg
    import eep_prot_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int unsigned ARR_BASE  = 32'h0800,
    parameter int unsigned ARR_BYTES = 2048,
    parameter int          N_BLK     = 6,
    parameter int unsigned SHW_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special_mode,
    input  logic              pgm_active,
    input  logic [3:0]        shadow_nib,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [7:0]        bus_wdata,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [1:0]        erase_kind,
    input  logic              bulk_prot,
    output logic [7:0]        cfg_q,
    output logic [7:0]        prot_q,
    output logic              chk_protected,
    output logic              shadow_visible,
    output logic              bulk_row_block
);

    localparam int unsigned SHW_LO = ARR_BASE + ARR_BYTES - (ARR_BYTES >> (N_BLK - 1));

    logic cfg_wr, prot_wr, lock_bit, shw_hit;
    logic kind_wide;
    logic [31:0] a_ext;

    assign cfg_wr  = bus_wr && !bus_sel;
    assign prot_wr = bus_wr &&  bus_sel;
    assign a_ext   = 32'(chk_addr);

    eep_lock_fsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .special   (special_mode),
        .lock_wbit (bus_wdata[CFG_LOCK]),
        .lock      (lock_bit)
    );

    eep_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .special     (special_mode),
        .shadow_nib  (shadow_nib),
        .hi_wdata    (bus_wdata[7:4]),
        .wstop_wdata (bus_wdata[CFG_WAIT_STOP]),
        .dummy_wdata (bus_wdata[CFG_DUMMY]),
        .lock_bit    (lock_bit),
        .cfg_q       (cfg_q)
    );

    eep_prot_reg #(.N_BLK(N_BLK)) u_prot (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_wr    (prot_wr),
        .pgm_active (pgm_active),
        .lock_bit   (lock_bit),
        .shw_wdata  (bus_wdata[PRT_SHW]),
        .blk_wdata  (bus_wdata[N_BLK-1:0]),
        .prot_q     (prot_q)
    );

    assign shadow_visible = !cfg_q[CFG_SHW_OFF];

    eep_addr_check #(
        .ADDR_W    (ADDR_W),
        .ARR_BASE  (ARR_BASE),
        .ARR_BYTES (ARR_BYTES),
        .N_BLK     (N_BLK),
        .SHW_BYTES (SHW_BYTES)
    ) u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (chk_addr),
        .blk_prot    (prot_q[N_BLK-1:0]),
        .shw_prot    (prot_q[PRT_SHW]),
        .shw_visible (shadow_visible),
        .hit_prot    (chk_protected),
        .shw_hit     (shw_hit)
    );

    // byte and word erases never consult the bulk-protect bit
    assign kind_wide      = (erase_kind == ERS_BULK) || (erase_kind == ERS_ROW);
    assign bulk_row_block = (bulk_prot && kind_wide)
                          || ((erase_kind == ERS_BULK) && !shadow_visible);

    // R10: a visible, protected shadow word reports protected at the port
    p_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[CFG_SHW_OFF] && prot_q[PRT_SHW] && a_ext >= SHW_LO && a_ext < SHW_LO + SHW_BYTES)
        |-> chk_protected);

    // R10: shadow hit never claimed while the shadow word is hidden
    p_shadow_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CFG_SHW_OFF] |-> !shw_hit);

    // R11: bulk erase refused with the shadow word hidden
    p_bulk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_kind == 2'b00 && cfg_q[CFG_SHW_OFF]) |-> bulk_row_block);

endmodule

// File: tb/eep_prot_cfg_tb.sv
`timescale 1ns/1ps
module eep_prot_cfg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        special_mode = 1'b0;
    logic        pgm_active = 1'b0;
    logic [3:0]  shadow_nib = 4'h0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [11:0] chk_addr = 12'h000;
    logic [1:0]  erase_kind = 2'b10;
    logic        bulk_prot = 1'b0;
    logic [7:0]  cfg_q, prot_q;
    logic        chk_protected, shadow_visible, bulk_row_block;

    eep_prot_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .pgm_active(pgm_active),
        .shadow_nib(shadow_nib), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .chk_addr(chk_addr), .erase_kind(erase_kind), .bulk_prot(bulk_prot),
        .cfg_q(cfg_q), .prot_q(prot_q), .chk_protected(chk_protected),
        .shadow_visible(shadow_visible), .bulk_row_block(bulk_row_block)
    );

    always #2 clk = ~clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // behavioural reference state
    bit [3:0] m_hi;
    bit       m_wstop, m_lock, m_dummy, m_spent, m_last_spec;
    bit [7:0] m_prot;

    task automatic chk(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit ref_prot(int a, bit [7:0] p, bit shw_vis);
        bit r;
        if (a < 'h800)      r = 1'b0;
        else if (a < 'hC00) r = p[5];
        else if (a < 'hE00) r = p[4];
        else if (a < 'hF00) r = p[3];
        else if (a < 'hF80) r = p[2];
        else if (a < 'hFC0) r = p[1];
        else                r = p[0];
        if (shw_vis && (a == 'hFC0 || a == 'hFC1) && p[7]) r = 1'b1;
        return r;
    endfunction

    task automatic compare_all();
        bit vis;
        bit exp_blk;
        int a;
        vis = !m_hi[2];
        a   = int'(chk_addr);
        chk("R5", int'(cfg_q[7:5]), int'(m_hi[3:1]));
        chk("R6", int'(cfg_q[4]), int'(m_hi[0]));
        chk("R7", int'({cfg_q[3], cfg_q[2], cfg_q[0]}), int'({1'b1, m_wstop, m_dummy}));
        if (m_last_spec) chk("R4", int'(cfg_q[1]), int'(m_lock));
        else             chk("R3", int'(cfg_q[1]), int'(m_lock));
        chk("R2", int'(prot_q), int'(m_prot));
        if (a < 'h800)                                  chk("R9", int'(chk_protected), 0);
        else if (vis && (a == 'hFC0 || a == 'hFC1))     chk("R10", int'(chk_protected), int'(ref_prot(a, m_prot, vis)));
        else                                            chk("R8", int'(chk_protected), int'(ref_prot(a, m_prot, vis)));
        chk("R10", int'(shadow_visible), int'(vis));
        exp_blk = (bulk_prot && erase_kind < 2) || (erase_kind == 0 && !vis);
        chk("R11", int'(bulk_row_block), int'(exp_blk));
    endtask

    task automatic model_write();
        if (!bus_wr) return;
        if (!bus_sel) begin
            if (special_mode) begin
                m_hi   = bus_wdata[7:4];
                m_lock = bus_wdata[1];
            end else begin
                m_hi[0] = m_hi[0] & bus_wdata[4];
                if (!m_spent) begin
                    m_lock  = bus_wdata[1];
                    m_spent = 1'b1;
                end
            end
            m_last_spec = special_mode;
            m_wstop = bus_wdata[2];
            m_dummy = bus_wdata[0];
        end else if (!pgm_active && !m_lock) begin
            m_prot = {bus_wdata[7], 1'b1, bus_wdata[5:0]};
        end
    endtask

    task automatic step(bit wr, bit sel, bit [7:0] wd, bit spec, bit pgm,
                        bit [11:0] addr, bit [1:0] kind, bit bp);
        @(negedge clk);
        bus_wr = wr; bus_sel = sel; bus_wdata = wd; special_mode = spec;
        pgm_active = pgm; chk_addr = addr; erase_kind = kind; bulk_prot = bp;
        #1;
        compare_all();
        model_write();
    endtask

    task automatic do_reset(bit [3:0] nib);
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; shadow_nib = nib;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset values
        chk("R1", int'(cfg_q), int'({nib, 4'b1100}));
        chk("R1", int'(prot_q), 'hFF);
        m_hi = nib; m_wstop = 1'b1; m_lock = 1'b0; m_dummy = 1'b0;
        m_spent = 1'b0; m_last_spec = 1'b0; m_prot = 8'hFF;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1: got hung run expected completion (watchdog)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit [11:0] sweep [16];
        sweep = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hDFF, 12'hE00, 12'hEFF,
                  12'hF00, 12'hF7F, 12'hF80, 12'hFBF, 12'hFC0, 12'hFC1, 12'hFC2, 12'hFFF};

        do_reset(4'b1001);   // shadow visible, flash-open set

        // R8/R10: single protect bit sweeps over every boundary
        for (int k = 0; k < 8; k++) begin
            step(1, 1, 8'(1 << k), 0, 0, 12'h800, 2'b10, 0);
            for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, sweep[i], 2'(i % 4), 1'(i % 2));
        end

        // R2: protection write ignored while a pulse is applied
        step(1, 1, 8'h00, 0, 1, 12'hFC0, 2'b00, 0);
        step(0, 0, 0, 0, 0, 12'hFC0, 2'b00, 1);
        // R6: normal write of 1 cannot raise flash-open, 0 clears it
        step(1, 0, 8'hF0, 0, 0, 12'h900, 2'b01, 1);
        // R3: the first normal write above already spent the token; lock stays 0
        step(1, 0, 8'h02, 0, 0, 12'h900, 2'b01, 0);
        step(1, 1, 8'h3F, 0, 0, 12'hFC1, 2'b10, 0);
        // R4: special writes set and clear the lock freely
        step(1, 0, 8'h42, 1, 0, 12'hFC1, 2'b00, 0);
        step(1, 1, 8'h00, 0, 0, 12'hFC1, 2'b00, 0);   // frozen by lock
        step(1, 0, 8'h04, 1, 0, 12'hFC1, 2'b00, 0);
        step(1, 1, 8'h80, 0, 0, 12'hFC1, 2'b00, 0);
        step(0, 0, 0, 0, 0, 12'hFC0, 2'b00, 0);

        // R3: fresh token, first normal write sets lock, later cannot clear
        do_reset(4'b0110);   // shadow hidden
        step(1, 0, 8'h03, 0, 0, 12'hFC0, 2'b00, 0);
        step(1, 0, 8'h00, 0, 0, 12'hFC0, 2'b00, 0);
        step(1, 1, 8'h00, 0, 0, 12'hFC0, 2'b01, 1);
        step(0, 0, 0, 0, 0, 12'hFC0, 2'b11, 1);

        // pseudo-random epochs
        for (int e = 0; e < 6; e++) begin
            do_reset(4'($urandom_range(0, 15)));
            for (int c = 0; c < 400; c++) begin
                bit [11:0] a;
                if (c % 3 == 0) a = 12'($urandom_range(0, 'hFFF));
                else if (c % 3 == 1) a = 12'($urandom_range('h7F0, 'hFFF));
                else a = 12'($urandom_range('hFBE, 'hFC3));
                step(1'($urandom_range(0, 9) < 4), 1'($urandom_range(0, 1)),
                     8'($urandom_range(0, 255)), 1'($urandom_range(0, 3) == 0),
                     1'($urandom_range(0, 3) == 0), a, 2'($urandom_range(0, 3)),
                     1'($urandom_range(0, 1)));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule